// File: doc/BRIEF.md
# Address-Match Breakpoint Trigger Bank

This block holds a small bank of debug triggers for a 64-bit core. Software reaches it through a narrow register port with three views. The first is an index that picks one trigger. The second is that trigger's control word, which carries a fixed type field and the access enables. The third is that trigger's match address. The index view is global, and the other two views act on the selected trigger only.

On every cycle the core presents its instruction fetch address, load address and store address, each with a valid flag. Each trigger that is enabled compares its own access kinds against the matching port with a full-width equality. Any hit raises a breakpoint request with cause code 3 in the same cycle, so the core can take the exception before the access has any effect. The block also raises a per-port block flag. This flag cancels the instruction, stops the load writeback, or drops the memory write. The faulting address is reported with it, and for an execute hit that address is the PC of the instruction that did not run.

Control-word writes are legalised. Only machine-mode matching is built, so a combination that would need another privilege level reads back different from what was written. Software can use that readback to probe what the block supports.

Top module: `trig_unit`

## Requirements
- R1: Register port address 0 is the trigger index. A written value below the trigger count (2) is taken. Any larger value leaves the index unchanged, so it reads back different from what was written. The index reads back zero-extended.
- R2: Reading the control word (port address 1) always returns 2 in bits 63:60, whatever was written there. Bits 59:11 always read 0.
- R3: The control word keeps four enable bits: machine-mode at bit 6, execute at bit 2, store at bit 1 and load at bit 0. Every other bit below bit 11 is dropped on write and reads 0.
- R4: If a control write has the machine-mode bit clear, all four enables of that trigger are stored as 0. Any execute, load or store request in that write therefore reads back cleared.
- R5: After reset the index is 0, and every trigger has all enables at 0 and a match address of 0. Port address 3 reads 0.
- R6: A trigger with machine-mode and execute set fires on a valid fetch whose address equals its match address. In that cycle `brk_req` and `fetch_block` are 1 and `brk_tval` equals the fetch address.
- R7: A trigger with machine-mode and load set fires on a valid load from its match address and raises `load_block`. A store to that address does not fire it unless store is also enabled.
- R8: A trigger with machine-mode and store set fires on a valid store to its match address and raises `store_block`. A load from that address does not fire it unless load is also enabled.
- R9: Each trigger keeps its own enables and match address. Both triggers can hit in the same cycle, each on its own address and access kinds.
- R10: `brk_cause` is 3 while `brk_req` is 1 and 0 otherwise. `brk_req` is 1 exactly when at least one block flag is 1.
- R11: Matching is an exact 64-bit equality. An address that differs only in bit 63, or the next sequential instruction address (match + 4), does not fire.
- R12: When several ports hit in one cycle, `brk_tval` takes the fetch address first, then the load address, then the store address. With no hit it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_we | input | 1 | Register write strobe |
| csr_addr | input | 2 | 0 index, 1 control word, 2 match address, 3 unused |
| csr_wdata | input | 64 | Register write data |
| csr_rdata | output | 64 | Register read data (combinational) |
| fetch_valid | input | 1 | Fetch address is valid |
| fetch_addr | input | 64 | Instruction fetch address |
| load_valid | input | 1 | Load address is valid |
| load_addr | input | 64 | Load address |
| store_valid | input | 1 | Store address is valid |
| store_addr | input | 64 | Store address |
| brk_req | output | 1 | Breakpoint exception request |
| brk_cause | output | 6 | Exception cause code |
| brk_tval | output | 64 | Address that hit |
| fetch_block | output | 1 | Cancel the fetched instruction |
| load_block | output | 1 | Suppress load writeback |
| store_block | output | 1 | Suppress memory write |

## Verification
The bench sweeps all 16 enable combinations on both triggers against every mix of three addresses on the three ports: match 0, match 1, and a near miss that differs only in bit 63. This exposes a design that ties load and store enables together, because a store would then fire a load-only trigger. It also exposes triggers that share state, because one trigger would then fire on the other's address. A design that compares only the low address bits would fire on the near miss. Writes of an out-of-range index would reach a missing trigger if legalisation were wrong. A control word that kept execute without machine-mode would read back unchanged and still fire. The bench also checks that the address of the next instruction after a breakpoint does not fire again.

// File: rtl/trig_pkg.sv
package trig_pkg;
    localparam int TYPE_ADDR_MATCH = 2;
    localparam int BIT_M = 6;
    localparam int BIT_X = 2;
    localparam int BIT_S = 1;
    localparam int BIT_L = 0;
    localparam int CAUSE_BREAK = 3;

    typedef enum logic [1:0] {
        REG_SEL   = 2'd0,
        REG_CTRL  = 2'd1,
        REG_MATCH = 2'd2,
        REG_NONE  = 2'd3
    } trig_reg_e;

    typedef struct packed {
        logic m;
        logic x;
        logic l;
        logic s;
    } trig_en_t;
endpackage

// File: rtl/trig_legal.sv
module trig_legal
    import trig_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] wdata,
    output trig_en_t        legal
);
    // Only machine-mode matching exists: without it nothing may be enabled.
    always_comb begin
        if (wdata[BIT_M]) begin
            legal.m = 1'b1;
            legal.x = wdata[BIT_X];
            legal.l = wdata[BIT_L];
            legal.s = wdata[BIT_S];
        end else begin
            legal = '0;
        end
    end
endmodule

// File: rtl/trig_slot.sv
module trig_slot
    import trig_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ctrl_we,
    input  logic            match_we,
    input  logic [XLEN-1:0] wdata,
    input  logic            fetch_valid,
    input  logic [XLEN-1:0] fetch_addr,
    input  logic            load_valid,
    input  logic [XLEN-1:0] load_addr,
    input  logic            store_valid,
    input  logic [XLEN-1:0] store_addr,
    output trig_en_t        en_o,
    output logic [XLEN-1:0] match_o,
    output logic            hit_f,
    output logic            hit_l,
    output logic            hit_s
);
    trig_en_t        en_q;
    trig_en_t        en_legal;
    logic [XLEN-1:0] match_q;

    trig_legal #(.XLEN(XLEN)) legal_i (
        .wdata (wdata),
        .legal (en_legal)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= '0;
            match_q <= '0;
        end else begin
            if (ctrl_we)  en_q    <= en_legal;
            if (match_we) match_q <= wdata;
        end
    end

    always_comb begin
        hit_f = en_q.m && en_q.x && fetch_valid && (fetch_addr == match_q);
        hit_l = en_q.m && en_q.l && load_valid  && (load_addr  == match_q);
        hit_s = en_q.m && en_q.s && store_valid && (store_addr == match_q);
    end

    assign en_o    = en_q;
    assign match_o = match_q;
endmodule

// File: rtl/trig_unit.sv
module trig_unit
    import trig_pkg::*;
#(
    parameter int XLEN    = 64,
    parameter int NTRIG   = 2,
    parameter int CAUSE_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               csr_we,
    input  logic [1:0]         csr_addr,
    input  logic [XLEN-1:0]    csr_wdata,
    output logic [XLEN-1:0]    csr_rdata,
    input  logic               fetch_valid,
    input  logic [XLEN-1:0]    fetch_addr,
    input  logic               load_valid,
    input  logic [XLEN-1:0]    load_addr,
    input  logic               store_valid,
    input  logic [XLEN-1:0]    store_addr,
    output logic               brk_req,
    output logic [CAUSE_W-1:0] brk_cause,
    output logic [XLEN-1:0]    brk_tval,
    output logic               fetch_block,
    output logic               load_block,
    output logic               store_block
);
    localparam int SEL_W = (NTRIG > 1) ? $clog2(NTRIG) : 1;

    trig_reg_e       reg_sel;
    logic [SEL_W-1:0] sel_q;
    trig_en_t        en_v    [NTRIG];
    logic [XLEN-1:0] match_v [NTRIG];
    logic [NTRIG-1:0] hf, hl, hs;
    trig_en_t        rd_en;
    logic [XLEN-1:0] rd_match;

    assign reg_sel = trig_reg_e'(csr_addr);

    always_ff @(posedge clk) begin
        if (!rst_n)
            sel_q <= '0;
        else if (csr_we && reg_sel == REG_SEL && csr_wdata < XLEN'(NTRIG))
            sel_q <= csr_wdata[SEL_W-1:0];
    end

    for (genvar g = 0; g < NTRIG; g++) begin : g_slot
        trig_slot #(.XLEN(XLEN)) slot_i (
            .clk         (clk),
            .rst_n       (rst_n),
            .ctrl_we     (csr_we && reg_sel == REG_CTRL  && sel_q == SEL_W'(g)),
            .match_we    (csr_we && reg_sel == REG_MATCH && sel_q == SEL_W'(g)),
            .wdata       (csr_wdata),
            .fetch_valid (fetch_valid),
            .fetch_addr  (fetch_addr),
            .load_valid  (load_valid),
            .load_addr   (load_addr),
            .store_valid (store_valid),
            .store_addr  (store_addr),
            .en_o        (en_v[g]),
            .match_o     (match_v[g]),
            .hit_f       (hf[g]),
            .hit_l       (hl[g]),
            .hit_s       (hs[g])
        );
    end

    always_comb begin
        rd_en    = '0;
        rd_match = '0;
        for (int i = 0; i < NTRIG; i++) begin
            if (sel_q == SEL_W'(i)) begin
                rd_en    = en_v[i];
                rd_match = match_v[i];
            end
        end
    end

    always_comb begin
        csr_rdata = '0;
        unique case (reg_sel)
            REG_SEL:   csr_rdata = XLEN'(sel_q);
            REG_CTRL: begin
                csr_rdata[XLEN-1 -: 4] = 4'(TYPE_ADDR_MATCH);
                csr_rdata[BIT_M] = rd_en.m;
                csr_rdata[BIT_X] = rd_en.x;
                csr_rdata[BIT_S] = rd_en.s;
                csr_rdata[BIT_L] = rd_en.l;
            end
            REG_MATCH: csr_rdata = rd_match;
            REG_NONE:  csr_rdata = '0;
        endcase
    end

    always_comb begin
        fetch_block = |hf;
        load_block  = |hl;
        store_block = |hs;
        brk_req     = fetch_block || load_block || store_block;
        brk_cause   = brk_req ? CAUSE_W'(CAUSE_BREAK) : '0;
        if (fetch_block)      brk_tval = fetch_addr;
        else if (load_block)  brk_tval = load_addr;
        else if (store_block) brk_tval = store_addr;
        else                  brk_tval = '0;
    end
endmodule

// File: rtl/trig_unit_chk.sv
module trig_unit_chk #(
    parameter int XLEN    = 64,
    parameter int NTRIG   = 2,
    parameter int CAUSE_W = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic               csr_we,
    input logic [1:0]         csr_addr,
    input logic [XLEN-1:0]    csr_wdata,
    input logic [XLEN-1:0]    csr_rdata,
    input logic               fetch_valid,
    input logic [XLEN-1:0]    fetch_addr,
    input logic               load_valid,
    input logic               store_valid,
    input logic               brk_req,
    input logic [CAUSE_W-1:0] brk_cause,
    input logic [XLEN-1:0]    brk_tval,
    input logic               fetch_block,
    input logic               load_block,
    input logic               store_block
);
    AST_SEL_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        csr_addr == 2'd0 |-> csr_rdata < XLEN'(NTRIG)); // R1
    AST_SEL_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_we && csr_addr == 2'd0 && csr_wdata < XLEN'(NTRIG))
        |=> (csr_addr != 2'd0 || csr_rdata == $past(csr_wdata))); // R1
    AST_TYPE_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        csr_addr == 2'd1 |-> csr_rdata[XLEN-1 -: 4] == 4'd2); // R2
    AST_CTRL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        csr_addr == 2'd1 |-> (csr_rdata[6] || csr_rdata[2:0] == 3'd0)); // R4
    AST_FETCH_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_block |-> fetch_valid && brk_tval == fetch_addr); // R6
    AST_LOAD_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        load_block |-> load_valid); // R7
    AST_STORE_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        store_block |-> store_valid); // R8
    AST_CAUSE_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        brk_req |-> brk_cause == CAUSE_W'(3)); // R10
    AST_CAUSE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !brk_req |-> brk_cause == '0 && brk_tval == '0); // R10
    AST_REQ_SOURCES: assert property (@(posedge clk) disable iff (!rst_n)
        brk_req == (fetch_block || load_block || store_block)); // R10
endmodule

bind trig_unit trig_unit_chk #(.XLEN(XLEN), .NTRIG(NTRIG), .CAUSE_W(CAUSE_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .csr_we      (csr_we),
    .csr_addr    (csr_addr),
    .csr_wdata   (csr_wdata),
    .csr_rdata   (csr_rdata),
    .fetch_valid (fetch_valid),
    .fetch_addr  (fetch_addr),
    .load_valid  (load_valid),
    .store_valid (store_valid),
    .brk_req     (brk_req),
    .brk_cause   (brk_cause),
    .brk_tval    (brk_tval),
    .fetch_block (fetch_block),
    .load_block  (load_block),
    .store_block (store_block)
);

// File: tb/trig_unit_tb.sv
module trig_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [63:0] A0   = 64'h8000_0000_0000_1000;
    localparam logic [63:0] A1   = 64'h0000_0000_0000_2004;
    localparam logic [63:0] NEAR = 64'h0000_0000_0000_1000;
    localparam logic [63:0] TYPE_WORD = 64'h2000_0000_0000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_we = 1'b0;
    logic [1:0]  csr_addr = 2'd0;
    logic [63:0] csr_wdata = '0;
    logic [63:0] csr_rdata;
    logic        fetch_valid = 1'b0, load_valid = 1'b0, store_valid = 1'b0;
    logic [63:0] fetch_addr = '0, load_addr = '0, store_addr = '0;
    logic        brk_req, fetch_block, load_block, store_block;
    logic [5:0]  brk_cause;
    logic [63:0] brk_tval;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    trig_unit dut_i (
        .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
        .load_valid(load_valid), .load_addr(load_addr),
        .store_valid(store_valid), .store_addr(store_addr),
        .brk_req(brk_req), .brk_cause(brk_cause), .brk_tval(brk_tval),
        .fetch_block(fetch_block), .load_block(load_block), .store_block(store_block)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [63:0] d);
        csr_we = 1'b1; csr_addr = a; csr_wdata = d;
        @(posedge clk); #1;
        csr_we = 1'b0; csr_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [63:0] d);
        csr_addr = a; #1; d = csr_rdata;
    endtask

    function automatic logic [63:0] enc(input logic [3:0] c);
        // c = {s, l, x, m}; junk in bits 3, 10 and 59 must be dropped
        return (64'(c[0]) << 6) | (64'(c[1]) << 2) | (64'(c[2]) << 0)
             | (64'(c[3]) << 1) | 64'h0800_0000_0000_0408;
    endfunction

    function automatic logic [3:0] leg(input logic [3:0] c);
        return c[0] ? c : 4'd0;
    endfunction

    function automatic logic [63:0] pick(input int k);
        return (k == 0) ? A0 : (k == 1) ? A1 : NEAR;
    endfunction

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
        finish_run();
    end

    initial begin
        logic [63:0] v;
        logic [63:0] exp_sel;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R5 reset state
        rd(2'd0, v); chk(v == 64'd0, "R5 index", v, 64'd0);
        for (int t = 0; t < 2; t++) begin
            wr(2'd0, 64'(t));
            rd(2'd1, v); chk(v == TYPE_WORD, "R5 ctrl", v, TYPE_WORD);
            rd(2'd2, v); chk(v == 64'd0, "R5 match", v, 64'd0);
        end
        rd(2'd3, v); chk(v == 64'd0, "R5 unused addr", v, 64'd0);

        // R1 index legalisation sweep
        exp_sel = 64'd1;
        for (int s = 0; s < 8; s++) begin
            wr(2'd0, 64'(s));
            if (s < 2) exp_sel = 64'(s);
            rd(2'd0, v); chk(v == exp_sel, "R1 index", v, exp_sel);
        end
        wr(2'd0, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(2'd0, v); chk(v == exp_sel, "R1 index all-ones", v, exp_sel);

        // R9 independent match addresses
        wr(2'd0, 64'd0); wr(2'd2, A0);
        wr(2'd0, 64'd1); wr(2'd2, A1);
        rd(2'd2, v); chk(v == A1, "R9 match1", v, A1);
        wr(2'd0, 64'd0);
        rd(2'd2, v); chk(v == A0, "R9 match0", v, A0);

        // control legalisation and hit sweep over both triggers
        for (int c0 = 0; c0 < 16; c0++) begin
            for (int c1 = 0; c1 < 16; c1++) begin
                logic [3:0] l0, l1;
                l0 = leg(4'(c0)); l1 = leg(4'(c1));
                wr(2'd0, 64'd0); wr(2'd1, enc(4'(c0)));
                wr(2'd0, 64'd1); wr(2'd1, enc(4'(c1)));
                rd(2'd1, v);
                chk(v == (TYPE_WORD | (enc(l1) & 64'h47)), "R2 R3 R4 ctrl1", v,
                    TYPE_WORD | (enc(l1) & 64'h47));
                wr(2'd0, 64'd0);
                rd(2'd1, v);
                chk(v == (TYPE_WORD | (enc(l0) & 64'h47)), "R2 R3 R4 ctrl0", v,
                    TYPE_WORD | (enc(l0) & 64'h47));
                for (int kf = 0; kf < 3; kf++) begin
                    for (int kl = 0; kl < 3; kl++) begin
                        for (int ks = 0; ks < 3; ks++) begin
                            logic ef, el, es, er;
                            logic [63:0] et;
                            fetch_addr = pick(kf); load_addr = pick(kl); store_addr = pick(ks);
                            fetch_valid = 1'b1; load_valid = 1'b1; store_valid = 1'b1;
                            ef = (l0[1] && kf == 0) || (l1[1] && kf == 1);
                            el = (l0[2] && kl == 0) || (l1[2] && kl == 1);
                            es = (l0[3] && ks == 0) || (l1[3] && ks == 1);
                            er = ef || el || es;
                            et = ef ? fetch_addr : el ? load_addr : es ? store_addr : 64'd0;
                            #1;
                            chk(fetch_block == ef, "R6 R9 R11 fetch_block", 64'(fetch_block), 64'(ef));
                            chk(load_block == el, "R7 R9 R11 load_block", 64'(load_block), 64'(el));
                            chk(store_block == es, "R8 R9 R11 store_block", 64'(store_block), 64'(es));
                            chk(brk_req == er && brk_cause == (er ? 6'd3 : 6'd0), "R10 req/cause",
                                {56'd0, brk_req, 1'b0, brk_cause}, {56'd0, er, 1'b0, er ? 6'd3 : 6'd0});
                            chk(brk_tval == et, "R12 tval", brk_tval, et);
                        end
                    end
                end
                fetch_valid = 1'b0; load_valid = 1'b0; store_valid = 1'b0;
                #1;
                chk(brk_req == 1'b0, "R10 idle", 64'(brk_req), 64'd0);
            end
        end

        // R11 next sequential fetch after an execute hit does not fire
        wr(2'd0, 64'd0); wr(2'd1, 64'h44);
        fetch_valid = 1'b1; fetch_addr = A0; #1;
        chk(fetch_block && brk_tval == A0, "R6 exec hit pc", brk_tval, A0);
        fetch_addr = A0 + 64'd4; #1;
        chk(!brk_req, "R11 resume at pc+4", 64'(brk_req), 64'd0);
        fetch_valid = 1'b0; #1;

        finish_run();
    end
endmodule